// File: doc/BRIEF.md
# Single-Precision Float / Integer Converter

This block turns a 32-bit IEEE single-precision value into a signed or unsigned integer of 8, 16 or 32 bits, or turns such an integer into a single-precision value. A one-bit direction input picks the way of conversion. A two-bit width code and a signedness bit pick the integer format. Both the operand and the result travel on 32-bit buses, and a valid strobe qualifies each one. The result and its two flags appear one clock after the operand.

Float-to-integer conversion drops the fraction, so it rounds toward zero. A value that lies beyond the target range clamps to the nearest representable bound and raises the invalid flag. Denormal inputs count as zero, and NaN gives zero. Integer-to-float conversion is exact while the magnitude fits in 24 significant bits. Above that, it rounds under a two-bit mode input and raises an inexact flag whenever it drops nonzero bits.

Top module: `fcvt_unit`

## Requirements
- R1: Float-to-integer (dir=0) with a finite in-range operand gives the value rounded toward zero. For a signed target the integer is sign-extended to 32 bits, and for an unsigned target it is zero-extended. The width code is 00=8 bits, 01=16 bits, 10 or 11=32 bits, and is_signed=1 selects a signed target.
- R2: Float-to-integer with a finite value whose truncation lies beyond the target range gives the target maximum or minimum, extended as in R1, and sets flag_invalid.
- R3: A negative float converted to an unsigned target gives 0. flag_invalid is set when the magnitude is at least 1. When the magnitude is below 1 there is no flag.
- R4: A NaN operand (exponent all ones, nonzero fraction) gives 0 with flag_invalid. Plus infinity gives the target maximum and minus infinity gives the target minimum, both with flag_invalid.
- R5: An operand with exponent field 0 (zero or denormal) gives 0 without any flag.
- R6: Integer-to-float (dir=1) gives the exact single-precision value, with flag_inexact clear, when the magnitude is below 2^24. Zero gives +0.0.
- R7: Integer-to-float rounding follows round_mode: 00 nearest-even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity.
- R8: flag_inexact is set exactly when integer-to-float rounding drops nonzero bits. It is never set in float-to-integer mode, and flag_invalid is never set in integer-to-float mode.
- R9: out_valid equals in_valid of the previous cycle. While out_valid is low, out_data and both flags are 0.
- R10: In integer-to-float mode with an 8- or 16-bit width code, only the low 8 or 16 bits of in_data are read; the upper bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand qualifier |
| dir | input | 1 | 0 = float to integer, 1 = integer to float |
| int_width | input | 2 | Integer width code: 00=8, 01=16, 1x=32 |
| is_signed | input | 1 | Integer is two's complement when 1 |
| round_mode | input | 2 | Integer-to-float rounding mode |
| in_data | input | 32 | Float bits or integer operand |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 32 | Converted result |
| flag_invalid | output | 1 | NaN, infinity or out-of-range operand |
| flag_inexact | output | 1 | Integer-to-float result was rounded |

## Verification
The bench goes after the range edges, where an off-by-one in the bound comparison would either clamp values that fit or wrap the most negative signed value. Examples are 2^31 and -2^31 into a signed 32-bit target, and ±300 into 8 bits. Negative fractions into unsigned targets are also tried, since a design that skips the magnitude test would flag a clean zero. Integers just above 2^24, exact halfway values and all-ones unsigned words are fed through every rounding mode. This catches a wrong tie break, a mantissa carry that fails to bump the exponent, or a missed inexact flag. Garbage in the unused upper bits of narrow integers shows up at once as a wrong result if the design fails to mask or sign-extend them.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  localparam int MAX_E = BIAS + FP_W - 1;   // largest exponent giving |v| < 2^32

  typedef enum logic {DIR_F2I = 1'b0, DIR_I2F = 1'b1} dir_e;
  typedef enum logic [1:0] {RM_RNE = 2'd0, RM_RZ = 2'd1, RM_RUP = 2'd2, RM_RDN = 2'd3} rmode_e;

  function automatic int unsigned width_bits(logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/fcvt_lzc.sv
module fcvt_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++)
      if (vec[i]) zeros = CW'(W - 1 - i);
  end
endmodule

// File: rtl/fcvt_f2i.sv
module fcvt_f2i
  import fcvt_pkg::*;
(
  input  logic [FP_W-1:0] fbits,
  input  logic [1:0]      wcode,
  input  logic            sgn,
  output logic [FP_W-1:0] result,
  output logic            invalid
);
  localparam int WIDE_W = FP_W + MAN_W + 1;

  logic               neg;
  logic [EXP_W-1:0]   expo;
  logic [MAN_W-1:0]   frac;
  logic [4:0]         shamt;
  logic [WIDE_W-1:0]  wide;
  logic [FP_W:0]      mag, pos_lim, neg_lim;
  logic [FP_W-1:0]    sat_hi, sat_lo;
  int unsigned        nbits;

  always_comb begin
    neg     = fbits[FP_W-1];
    expo    = fbits[FP_W-2 -: EXP_W];
    frac    = fbits[MAN_W-1:0];
    nbits   = width_bits(wcode);
    pos_lim = sgn ? ((33'd1 << (nbits - 1)) - 33'd1) : ((33'd1 << nbits) - 33'd1);
    neg_lim = sgn ? (33'd1 << (nbits - 1)) : 33'd0;
    sat_hi  = pos_lim[FP_W-1:0];
    sat_lo  = FP_W'(-neg_lim);
    shamt   = 5'(expo - EXP_W'(BIAS));
    wide    = {{FP_W{1'b0}}, 1'b1, frac} << shamt;
    mag     = (FP_W+1)'(wide >> MAN_W);
    result  = '0;
    invalid = 1'b0;
    if (expo == {EXP_W{1'b1}}) begin
      invalid = 1'b1;
      if (frac == '0) result = neg ? sat_lo : sat_hi;
    end else if (expo < EXP_W'(BIAS)) begin
      result = '0;                        // zero, denormal or |v| < 1
    end else if (expo > EXP_W'(MAX_E)) begin
      invalid = 1'b1;
      result  = neg ? sat_lo : sat_hi;
    end else if (!neg) begin
      if (mag > pos_lim) begin
        invalid = 1'b1;
        result  = sat_hi;
      end else result = mag[FP_W-1:0];
    end else begin
      if (mag > neg_lim) begin
        invalid = 1'b1;
        result  = sat_lo;
      end else result = FP_W'(-mag);
    end
  end
endmodule

// File: rtl/fcvt_i2f.sv
module fcvt_i2f
  import fcvt_pkg::*;
(
  input  logic [FP_W-1:0] ibits,
  input  logic [1:0]      wcode,
  input  logic            sgn,
  input  logic [1:0]      rmode,
  output logic [FP_W-1:0] result,
  output logic            inexact
);
  localparam int CW = $clog2(FP_W) + 1;

  logic [FP_W-1:0]  ext, mag;
  logic             neg, guard, sticky, inc, carry;
  logic [CW-1:0]    lz;
  logic [FP_W-2:0]  norm;
  logic [MAN_W-1:0] frac_r;
  logic [EXP_W-1:0] expo;

  always_comb begin
    case (wcode)
      2'b00:   ext = sgn ? {{24{ibits[7]}},  ibits[7:0]}  : {24'd0, ibits[7:0]};
      2'b01:   ext = sgn ? {{16{ibits[15]}}, ibits[15:0]} : {16'd0, ibits[15:0]};
      default: ext = ibits;
    endcase
    neg = sgn & ext[FP_W-1];
    mag = neg ? -ext : ext;
  end

  fcvt_lzc #(.W(FP_W)) u_lzc (.vec(mag), .zeros(lz));

  always_comb begin
    norm   = (FP_W-1)'(mag << lz[CW-2:0]);
    guard  = norm[FP_W-MAN_W-2];
    sticky = |norm[FP_W-MAN_W-3:0];
    inexact = guard | sticky;
    case (rmode_e'(rmode))
      RM_RNE:  inc = guard & (sticky | norm[FP_W-MAN_W-1]);
      RM_RZ:   inc = 1'b0;
      RM_RUP:  inc = inexact & ~neg;
      default: inc = inexact & neg;
    endcase
    {carry, frac_r} = {1'b0, norm[FP_W-2 -: MAN_W]} + (MAN_W+1)'(inc);
    expo   = EXP_W'(MAX_E) - EXP_W'(lz) + EXP_W'(carry);
    result = (mag == '0) ? '0 : {neg, expo, frac_r};
  end
endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
  import fcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        dir,
  input  logic [1:0]  int_width,
  input  logic        is_signed,
  input  logic [1:0]  round_mode,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        flag_invalid,
  output logic        flag_inexact
);
  logic [FP_W-1:0] f2i_res, i2f_res;
  logic            f2i_inv, i2f_inx;
  logic            to_float;

  assign to_float = (dir_e'(dir) == DIR_I2F);

  fcvt_f2i u_f2i (.fbits(in_data), .wcode(int_width), .sgn(is_signed),
                  .result(f2i_res), .invalid(f2i_inv));
  fcvt_i2f u_i2f (.ibits(in_data), .wcode(int_width), .sgn(is_signed),
                  .rmode(round_mode), .result(i2f_res), .inexact(i2f_inx));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_data     <= in_valid ? (to_float ? i2f_res : f2i_res) : '0;
      flag_invalid <= in_valid & ~to_float & f2i_inv;
      flag_inexact <= in_valid & to_float & i2f_inx;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_data == '0 && !flag_invalid && !flag_inexact));
  // R8
  flag_mode_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (to_float_q ? !flag_invalid : !flag_inexact));
  // R4
  nan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir && in_data[30:23] == 8'hFF && in_data[22:0] != '0)
      |=> (out_data == '0 && flag_invalid));
  // R5
  denorm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir && in_data[30:23] == 8'h00) |=> (out_data == '0 && !flag_invalid));
  // R6
  small_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir && int_width != 2'b10 && int_width != 2'b11) |=> !flag_inexact);

  logic to_float_q;
  always_ff @(posedge clk) to_float_q <= to_float;
endmodule

// File: tb/tb_fcvt_unit.sv
`timescale 1ns/1ps
module tb_fcvt_unit;
  logic        clk = 1'b0, rst = 1'b1;
  logic        in_valid = 1'b0, dir = 1'b0, is_signed = 1'b0;
  logic [1:0]  int_width = 2'b00, round_mode = 2'b00;
  logic [31:0] in_data = '0;
  logic        out_valid, flag_invalid, flag_inexact;
  logic [31:0] out_data;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  fcvt_unit dut (.clk(clk), .rst(rst), .in_valid(in_valid), .dir(dir),
    .int_width(int_width), .is_signed(is_signed), .round_mode(round_mode),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact));

  function automatic int bits_of(logic [1:0] w);
    return (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
  endfunction

  function automatic longint trunc0(real v);
    longint q = longint'(v);
    if (v >= 0.0 && real'(q) > v) q--;
    if (v < 0.0 && real'(q) < v) q++;
    return q;
  endfunction

  function automatic void ref_f2i(logic [31:0] f, logic [1:0] w, logic s,
                                  output logic [31:0] r, output logic inv);
    int b = bits_of(w);
    longint hi = s ? (longint'(1) << (b-1)) - 1 : (longint'(1) << b) - 1;
    longint lo = s ? -(longint'(1) << (b-1)) : 0;
    int e = int'(f[30:23]);
    real v;
    inv = 1'b0; r = '0;
    if (e == 255) begin
      inv = 1'b1;
      if (f[22:0] == 0) r = 32'(f[31] ? lo : hi);
    end else if (e != 0) begin
      v = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** real'(e - 127));
      if (f[31]) v = -v;
      if (v >= real'(hi) + 1.0) begin inv = 1'b1; r = 32'(hi); end
      else if (v <= real'(lo) - 1.0) begin inv = 1'b1; r = 32'(lo); end
      else r = 32'(trunc0(v));
    end
  endfunction

  function automatic void ref_i2f(logic [31:0] d, logic [1:0] w, logic s, logic [1:0] rm,
                                  output logic [31:0] r, output logic inx);
    int b = bits_of(w);
    longint raw = longint'(d) & ((longint'(1) << b) - 1);
    longint x = (s && raw[b-1]) ? raw - (longint'(1) << b) : raw;
    logic ng = (x < 0);
    longint m = ng ? -x : x;
    longint q, rem, half;
    int k = 0;
    logic up;
    inx = 1'b0; r = '0;
    if (m != 0) begin
      while ((m >> k) >= (longint'(1) << 24)) k++;
      if (k > 0) begin
        q = m >> k; rem = m - (q << k); half = longint'(1) << (k-1);
        inx = (rem != 0);
        case (rm)
          2'd0: up = (rem > half) || (rem == half && q[0]);
          2'd1: up = 1'b0;
          2'd2: up = inx && !ng;
          default: up = inx && ng;
        endcase
        if (up) q++;
        if (q == (longint'(1) << 24)) begin q = q >> 1; k++; end
      end else begin
        q = m;
        while (q < (longint'(1) << 23)) begin q = q << 1; k--; end
      end
      r = {ng, 8'(150 + k), q[22:0]};
    end
  endfunction

  task automatic check(string tag, logic [31:0] ed, logic ei, logic ex);
    n_chk++;
    if (out_valid !== 1'b1 || out_data !== ed || flag_invalid !== ei || flag_inexact !== ex) begin
      n_bad++;
      $display("FAIL %s: act v=%b d=%h inv=%b inx=%b exp v=1 d=%h inv=%b inx=%b (in=%h dir=%b w=%b s=%b rm=%b)",
               tag, out_valid, out_data, flag_invalid, flag_inexact, ed, ei, ex,
               in_data, dir, int_width, is_signed, round_mode);
    end
  endtask

  // Drives at a falling edge, checks at the next falling edge.
  task automatic xact(logic d, logic [1:0] w, logic s, logic [1:0] rm, logic [31:0] v, string tag);
    logic [31:0] ed; logic ei, ex; string t;
    in_valid = 1'b1; dir = d; int_width = w; is_signed = s; round_mode = rm; in_data = v;
    if (!d) begin
      ref_f2i(v, w, s, ed, ei); ex = 1'b0;
      if (tag != "") t = tag;
      else if (v[30:23] == 8'hFF) t = "R4";
      else if (v[30:23] == 8'h00) t = "R5";
      else if (!s && v[31]) t = "R3";
      else if (ei) t = "R2";
      else t = "R1";
    end else begin
      ref_i2f(v, w, s, rm, ed, ex); ei = 1'b0;
      if (tag != "") t = tag;
      else if (w[1] == 1'b0) t = "R10";
      else if (ex) t = "R8";
      else t = "R6";
    end
    @(negedge clk);
    check(t, ed, ei, ex);
  endtask

  task automatic idle_check();
    in_valid = 1'b0; in_data = 32'hDEAD_BEEF; dir = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_data !== '0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: act v=%b d=%h inv=%b inx=%b exp v=0 d=0 inv=0 inx=0",
               out_valid, out_data, flag_invalid, flag_inexact);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    n_chk++;   // reset state, R9
    if (out_valid !== 1'b0 || out_data !== '0) begin
      n_bad++;
      $display("FAIL R9: act v=%b d=%h exp v=0 d=0", out_valid, out_data);
    end
    rst = 1'b0;
    @(negedge clk);
    // directed float-to-integer corners
    xact(0, 2'b10, 1, 0, 32'h406CCCCD, "R1");   // 3.7
    xact(0, 2'b10, 1, 0, 32'hC06CCCCD, "R1");   // -3.7
    xact(0, 2'b00, 1, 0, 32'h43960000, "R2");   // 300 -> s8
    xact(0, 2'b00, 1, 0, 32'hC3960000, "R2");   // -300 -> s8
    xact(0, 2'b10, 1, 0, 32'h4F000000, "R2");   // 2^31 -> s32
    xact(0, 2'b10, 1, 0, 32'hCF000000, "R1");   // -2^31 -> s32
    xact(0, 2'b00, 0, 0, 32'h437F0000, "R1");   // 255 -> u8
    xact(0, 2'b00, 0, 0, 32'hBF000000, "R3");   // -0.5 -> u8
    xact(0, 2'b01, 0, 0, 32'hBF800000, "R3");   // -1 -> u16
    xact(0, 2'b10, 1, 0, 32'h7FC00000, "R4");
    xact(0, 2'b10, 0, 0, 32'h7F800000, "R4");
    xact(0, 2'b01, 1, 0, 32'hFF800000, "R4");
    xact(0, 2'b10, 1, 0, 32'h00000001, "R5");
    xact(0, 2'b00, 1, 0, 32'h80000000, "R5");
    idle_check();
    // directed integer-to-float corners
    for (int m = 0; m < 4; m++) begin
      xact(1, 2'b10, 1, 2'(m), 32'h01000001, "R7");
      xact(1, 2'b10, 1, 2'(m), 32'hFEFFFFFF, "R7");
      xact(1, 2'b10, 1, 2'(m), 32'h01000003, "R7");
      xact(1, 2'b10, 0, 2'(m), 32'hFFFFFFFF, "R7");
      xact(1, 2'b10, 1, 2'(m), 32'h80000000, "R8");
    end
    xact(1, 2'b10, 1, 0, 32'h00FFFFFF, "R6");
    xact(1, 2'b10, 1, 0, 32'h00000000, "R6");
    xact(1, 2'b00, 1, 0, 32'hABCDEFFF, "R10");
    xact(1, 2'b01, 0, 0, 32'h5555FFFF, "R10");
    idle_check();
    // random float-to-integer
    for (int i = 0; i < 1500; i++) begin
      v = $urandom;
      case ($urandom_range(0, 9))
        0:       v[30:23] = 8'h00;
        1:       v[30:23] = 8'hFF;
        default: v[30:23] = 8'(110 + $urandom_range(0, 55));
      endcase
      xact(0, 2'($urandom), 1'($urandom), 2'($urandom), v, "");
      if (i % 200 == 0) idle_check();
    end
    // random integer-to-float
    for (int i = 0; i < 1500; i++) begin
      v = $urandom;
      if ($urandom_range(0, 3) == 0) v = v >> $urandom_range(0, 31);
      xact(1, 2'($urandom), 1'($urandom), 2'($urandom), v, "");
    end
    idle_check();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule